// File: doc/BRIEF.md
# Peripheral Interrupt Level Mapper

This block gathers the request lines of many peripherals and funnels each enabled request onto one of a small set of core priority lines. Software decides where each peripheral lands by writing a 4-bit selector for that source. Eight selectors are packed into each 32-bit assignment word. A per-source enable bit gates each request before routing. A second per-source bit decides whether a pending request raises a wake signal. The core sees one registered request line per priority level and one wake line. It does not see individual sources. Identifying the source is left to software, which reads the gated status words.

Registers are reached through a word-addressed port with separate read and write strobes. Read data comes back one cycle after the read strobe. The port is a two-state machine:
- `PORT_IDLE` is the state with no response pending.
- `PORT_RESP` is the state in which `rvalid_o` is high.
- The transition *read accepted* moves to `PORT_RESP` from either state whenever `rd_en_i` is high.
- The transition *port quiet* returns to `PORT_IDLE` whenever `rd_en_i` is low.

The status words are read-only views of the live request lines. A request is cleared at the peripheral that raised it.

With default parameters (64 sources, 7 levels, 5-bit address) the word map is:

| Address | Content | Access |
|---|---|---|
| 0–1 | enable bits | read/write |
| 2–3 | wake-enable bits | read/write |
| 4–5 | raw status | read-only |
| 6–7 | status AND enable | read-only |
| 8–15 | assignment words | read/write |
| 16–31 | unmapped | — |

Top module: `periph_irq_mapper`

## Requirements
- R1: After reset all enable bits and all wake-enable bits are 0. `lvl_req_o`, `wake_o` and `rvalid_o` are 0.
- R2: After reset, every selector in assignment word k holds min(k, NUM_LVL-1). Word k therefore reads as that nibble repeated eight times.
- R3: The selector of source n sits in assignment word n/8 (address 8+n/8) at bits (n mod 8)*4 to (n mod 8)*4+3. A selector value v routes the source to `lvl_req_o[v]`, which is core level 7+v.
- R4: A selector value of NUM_LVL (7) or above routes its source to no level line.
- R5: Source n contributes to a level line only when `irq_i[n]` is 1 and its enable bit is 1. The enable bit is bit n mod 32 of enable word n/32 (address n/32).
- R6: `lvl_req_o[v]` is registered. After a clock edge it equals the OR, over all sources, of the contributions present in the cycle before that edge.
- R7: `wake_o` is registered. It is 1 after an edge when some source had `irq_i[n]` = 1 and wake-enable bit n = 1 before that edge; the enable bits play no part. Wake-enable bit n is bit n mod 32 of address 2+n/32.
- R8: `rvalid_o` is 1 exactly in the cycle after a cycle with `rd_en_i` = 1. When a read and a write target the same word in one cycle, the read returns the value held before the write.
- R9: Reads return the word map above. Enable and wake words read back what was written. Assignment words read back the eight selectors of their sources.
- R10: Address 4+b returns `irq_i[32b+31:32b]` live, and address 6+b returns that value ANDed with enable word b. Writes to addresses 4 to 7 change no stored state.
- R11: Writes to addresses 16 and above change no stored state, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| irq_i | input | NUM_SRC | peripheral request lines, synchronous to clk |
| wr_en_i | input | 1 | write strobe |
| rd_en_i | input | 1 | read strobe |
| addr_i | input | ADDR_W | word address |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data, valid with rvalid_o |
| rvalid_o | output | 1 | read response strobe |
| lvl_req_o | output | NUM_LVL | request per core level (bit v = level 7+v) |
| wake_o | output | 1 | wake request |

## Verification
A change on `irq_i` shows on `lvl_req_o` and `wake_o` one edge later. A register write needs one edge to land and a second edge to reach the level and wake outputs. A read strobe yields `rvalid_o` and data one edge later, and the data reflects state before any write in the same cycle. The bench drives inputs on falling edges and updates a behavioural model on each rising edge from the same inputs. It compares outputs on the next falling edge, so each check sits on the cycle where that register count says the result is due. The directed checks are placed with the same counting: two falling edges after a write for level effects, and one after a read strobe for data.

// File: rtl/pim_pkg.sv
package pim_pkg;

    localparam int WORD_W          = 32;
    localparam int FIELD_W         = 4;
    localparam int FIELDS_PER_WORD = WORD_W / FIELD_W;

    typedef enum logic [0:0] {
        PORT_IDLE = 1'b0,
        PORT_RESP = 1'b1
    } port_state_e;

    // Reset value of assignment word k: every selector equals min(k, nlvl-1).
    function automatic logic [WORD_W-1:0] default_word(input int k, input int nlvl);
        logic [WORD_W-1:0] w;
        int f;
        f = (k < nlvl - 1) ? k : nlvl - 1;
        if (f < 0) f = 0;
        for (int j = 0; j < FIELDS_PER_WORD; j++) begin
            w[j*FIELD_W +: FIELD_W] = FIELD_W'(f);
        end
        return w;
    endfunction

endpackage

// File: rtl/pim_regs.sv
module pim_regs
    import pim_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_LVL = 7,
    parameter int ADDR_W  = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         irq_i,
    input  logic                       wr_en_i,
    input  logic                       rd_en_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [WORD_W-1:0]          wdata_i,
    output logic [NUM_SRC-1:0]         mask_o,
    output logic [NUM_SRC-1:0]         wake_en_o,
    output logic [NUM_SRC*FIELD_W-1:0] asg_o,
    output logic [WORD_W-1:0]          rdata_o,
    output logic                       rvalid_o
);

    localparam int NBANK      = NUM_SRC / WORD_W;
    localparam int NASG       = NUM_SRC / FIELDS_PER_WORD;
    localparam int MASK_BASE  = 0;
    localparam int WAKE_BASE  = NBANK;
    localparam int STAT_BASE  = 2 * NBANK;
    localparam int MSTAT_BASE = 3 * NBANK;
    localparam int ASG_BASE   = 4 * NBANK;
    localparam int MAP_END    = ASG_BASE + NASG;

    logic [NUM_SRC-1:0]         mask_q;
    logic [NUM_SRC-1:0]         wake_q;
    logic [NUM_SRC*FIELD_W-1:0] asg_q;
    logic [WORD_W-1:0]          rd_mux;
    logic [WORD_W-1:0]          rdata_q;
    port_state_e                state_q, state_d;
    int                         a_int;

    always_comb a_int = int'(addr_i);

    // Stored registers: enable, wake-enable, assignment words.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            wake_q <= '0;
            for (int k = 0; k < NASG; k++) begin
                asg_q[k*WORD_W +: WORD_W] <= default_word(k, NUM_LVL);
            end
        end else if (wr_en_i) begin
            for (int b = 0; b < NBANK; b++) begin
                if (a_int == MASK_BASE + b) mask_q[b*WORD_W +: WORD_W] <= wdata_i;
                if (a_int == WAKE_BASE + b) wake_q[b*WORD_W +: WORD_W] <= wdata_i;
            end
            for (int k = 0; k < NASG; k++) begin
                if (a_int == ASG_BASE + k) asg_q[k*WORD_W +: WORD_W] <= wdata_i;
            end
        end
    end

    // Read multiplexer over the word map; unmapped words read as zero.
    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (a_int == MASK_BASE + b)  rd_mux = mask_q[b*WORD_W +: WORD_W];
            if (a_int == WAKE_BASE + b)  rd_mux = wake_q[b*WORD_W +: WORD_W];
            if (a_int == STAT_BASE + b)  rd_mux = irq_i[b*WORD_W +: WORD_W];
            if (a_int == MSTAT_BASE + b) rd_mux = irq_i[b*WORD_W +: WORD_W]
                                                  & mask_q[b*WORD_W +: WORD_W];
        end
        for (int k = 0; k < NASG; k++) begin
            if (a_int == ASG_BASE + k) rd_mux = asg_q[k*WORD_W +: WORD_W];
        end
    end

    // Port state machine: next-state logic.
    always_comb begin
        unique case (state_q)
            PORT_IDLE: state_d = rd_en_i ? PORT_RESP : PORT_IDLE;
            PORT_RESP: state_d = rd_en_i ? PORT_RESP : PORT_IDLE;
            default:   state_d = PORT_IDLE;
        endcase
    end

    // Port state machine: state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PORT_IDLE;
        else        state_q <= state_d;
    end

    // Port state machine: output data register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_en_i) rdata_q <= rd_mux;
    end

    assign rvalid_o  = (state_q == PORT_RESP);
    assign rdata_o   = rdata_q;
    assign mask_o    = mask_q;
    assign wake_en_o = wake_q;
    assign asg_o     = asg_q;

    // R8: a read strobe is answered on the next cycle.
    a_r8_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rvalid_o);
    // R8: no response without a strobe.
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> !rvalid_o);
    // R10: writes to the status views leave stored state untouched.
    a_r10_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && a_int >= STAT_BASE && a_int < ASG_BASE)
        |=> ($stable(mask_q) && $stable(wake_q) && $stable(asg_q)));
    // R11: writes outside the map leave stored state untouched.
    a_r11_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && a_int >= MAP_END)
        |=> ($stable(mask_q) && $stable(wake_q) && $stable(asg_q)));

endmodule

// File: rtl/pim_route.sv
module pim_route
    import pim_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_LVL = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         irq_i,
    input  logic [NUM_SRC-1:0]         mask_i,
    input  logic [NUM_SRC-1:0]         wake_en_i,
    input  logic [NUM_SRC*FIELD_W-1:0] asg_i,
    output logic [NUM_LVL-1:0]         lvl_req_o,
    output logic                       wake_o
);

    logic [NUM_LVL-1:0][NUM_SRC-1:0] sel;
    logic [NUM_SRC-1:0]              live;
    logic [NUM_LVL-1:0]              hit;
    logic                            wake_hit;
    logic [NUM_LVL-1:0]              lvl_q;
    logic                            wake_q;

    assign live     = irq_i & mask_i;
    assign wake_hit = |(irq_i & wake_en_i);

    // One selector decode per (level, source); out-of-range values match nothing.
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
            assign sel[l][n] = (asg_i[n*FIELD_W +: FIELD_W] == FIELD_W'(l));
        end
        assign hit[l] = |(live & sel[l]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            wake_q <= 1'b0;
        end else begin
            lvl_q  <= hit;
            wake_q <= wake_hit;
        end
    end

    assign lvl_req_o = lvl_q;
    assign wake_o    = wake_q;

    // R5: with every enable bit clear no level line rises.
    a_r5_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |=> (lvl_req_o == '0));
    // R5: with no request pending no level line rises.
    a_r5_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i == '0) |=> (lvl_req_o == '0));
    // R7: wake needs a pending wake-enabled source.
    a_r7_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_i & wake_en_i) == '0) |=> !wake_o);

endmodule

// File: rtl/periph_irq_mapper.sv
module periph_irq_mapper
    import pim_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_LVL = 7,
    parameter int ADDR_W  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   irq_i,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [WORD_W-1:0]    wdata_i,
    output logic [WORD_W-1:0]    rdata_o,
    output logic                 rvalid_o,
    output logic [NUM_LVL-1:0]   lvl_req_o,
    output logic                 wake_o
);

    logic [NUM_SRC-1:0]         mask;
    logic [NUM_SRC-1:0]         wake_en;
    logic [NUM_SRC*FIELD_W-1:0] asg;

    pim_regs #(
        .NUM_SRC (NUM_SRC),
        .NUM_LVL (NUM_LVL),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_i     (irq_i),
        .wr_en_i   (wr_en_i),
        .rd_en_i   (rd_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .mask_o    (mask),
        .wake_en_o (wake_en),
        .asg_o     (asg),
        .rdata_o   (rdata_o),
        .rvalid_o  (rvalid_o)
    );

    pim_route #(
        .NUM_SRC (NUM_SRC),
        .NUM_LVL (NUM_LVL)
    ) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_i     (irq_i),
        .mask_i    (mask),
        .wake_en_i (wake_en),
        .asg_i     (asg),
        .lvl_req_o (lvl_req_o),
        .wake_o    (wake_o)
    );

endmodule

// File: tb/periph_irq_mapper_test.sv
`timescale 1ns/1ps
module periph_irq_mapper_test;

    localparam int NS = 64;
    localparam int NL = 7;
    localparam int AW = 5;
    localparam int NB = NS / 32;
    localparam int NA = NS / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          rvalid;
    logic [NL-1:0] lvl;
    logic          wake;

    always #2.5 clk = ~clk;

    periph_irq_mapper #(.NUM_SRC(NS), .NUM_LVL(NL), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
        .lvl_req_o(lvl), .wake_o(wake)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [NS-1:0] m_mask, m_wake;
    logic [3:0]    m_fld [NS];
    logic [NL-1:0] e_lvl;
    logic          e_wake, e_rv;
    logic [31:0]   e_rd;
    bit            m_live = 0;

    function automatic logic [31:0] m_read(input int a);
        logic [31:0] w;
        if (a < NB)            return m_mask[a*32 +: 32];
        else if (a < 2*NB)     return m_wake[(a-NB)*32 +: 32];
        else if (a < 3*NB)     return irq[(a-2*NB)*32 +: 32];
        else if (a < 4*NB)     return irq[(a-3*NB)*32 +: 32] & m_mask[(a-3*NB)*32 +: 32];
        else if (a < 4*NB+NA) begin
            for (int j = 0; j < 8; j++) w[j*4 +: 4] = m_fld[(a-4*NB)*8 + j];
            return w;
        end
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        m_live = 1;
        if (!rst_n) begin
            m_mask = '0; m_wake = '0;
            for (int n = 0; n < NS; n++) m_fld[n] = 4'((n/8 < NL-1) ? n/8 : NL-1);
            e_lvl = '0; e_wake = 0; e_rv = 0; e_rd = '0;
        end else begin
            e_lvl = '0;
            for (int n = 0; n < NS; n++)
                if (irq[n] && m_mask[n] && int'(m_fld[n]) < NL) e_lvl[m_fld[n]] = 1'b1;
            e_wake = |(irq & m_wake);
            e_rv   = rd_en;
            if (rd_en) e_rd = m_read(int'(addr));
            if (wr_en) begin
                if (int'(addr) < NB) m_mask[int'(addr)*32 +: 32] = wdata;
                else if (int'(addr) < 2*NB) m_wake[(int'(addr)-NB)*32 +: 32] = wdata;
                else if (int'(addr) >= 4*NB && int'(addr) < 4*NB+NA)
                    for (int j = 0; j < 8; j++) m_fld[(int'(addr)-4*NB)*8 + j] = wdata[j*4 +: 4];
            end
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (m_live && !done) begin
            chk(lvl == e_lvl, "R6 level lines vs model", 64'(lvl), 64'(e_lvl));
            chk(wake == e_wake, "R7 wake vs model", 64'(wake), 64'(e_wake));
            chk(rvalid == e_rv, "R8 rvalid vs model", 64'(rvalid), 64'(e_rv));
            if (e_rv) chk(rdata == e_rd, "R9 read data vs model", 64'(rdata), 64'(e_rd));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bus(input bit w, input bit r, input int a, input logic [31:0] d, output logic [31:0] q);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        q = rdata;
    endtask

    task automatic setirq(input logic [NS-1:0] v);
        @(negedge clk);
        irq = v;
        @(negedge clk);
    endtask

    logic [31:0] seed = 32'h1ACE_B00C;
    function automatic logic [31:0] rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    initial begin
        logic [31:0] q;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(lvl == '0, "R1 level lines in reset", 64'(lvl), 0);
        chk(wake == 0, "R1 wake in reset", 64'(wake), 0);
        chk(rvalid == 0, "R1 rvalid in reset", 64'(rvalid), 0);
        rst_n = 1'b1;
        for (int a = 0; a < 2*NB; a++) begin
            bus(0, 1, a, 0, q);
            chk(q == 0, "R1 enable/wake words cleared", 64'(q), 0);
        end
        // R2: default selectors
        for (int k = 0; k < NA; k++) begin
            bus(0, 1, 4*NB + k, 0, q);
            chk(q == 32'(((k < NL-1) ? k : NL-1)) * 32'h1111_1111, "R2 default assignment word",
                64'(q), 64'(32'(((k < NL-1) ? k : NL-1)) * 32'h1111_1111));
        end
        bus(1, 0, 0, 32'hFFFF_FFFF, q);
        bus(1, 0, 1, 32'hFFFF_FFFF, q);
        // R3: source 10 default level 1, then selector moved to 5
        setirq(64'd1 << 10);
        chk(lvl == 7'b0000010, "R3 source 10 default level", 64'(lvl), 64'h2);
        bus(1, 0, 9, 32'h0000_0500, q);
        setirq(64'd1 << 10);
        chk(lvl == 7'b0100000, "R3 source 10 selector=5", 64'(lvl), 64'h20);
        // R4: out-of-range selector
        bus(1, 0, 9, 32'h0000_0900, q);
        setirq(64'd1 << 10);
        chk(lvl == '0, "R4 selector 9 routes nowhere", 64'(lvl), 0);
        bus(1, 0, 9, 32'h0000_0700, q);
        setirq(64'd1 << 10);
        chk(lvl == '0, "R4 selector 7 routes nowhere", 64'(lvl), 0);
        // R5: enable gating, bank 1 bit 8 = source 40
        setirq(64'd1 << 40);
        chk(lvl == 7'b0100000, "R5 source 40 enabled", 64'(lvl), 64'h20);
        bus(1, 0, 1, ~(32'd1 << 8), q);
        setirq(64'd1 << 40);
        chk(lvl == '0, "R5 source 40 disabled", 64'(lvl), 0);
        setirq((64'd1 << 40) | 64'd1);
        chk(lvl == 7'b0000001, "R5 only enabled source passes", 64'(lvl), 64'h1);
        // R6: OR of several sources
        setirq(64'd1 | (64'd1 << 17) | (64'd1 << 63));
        chk(lvl == 7'b1000101, "R6 OR across sources", 64'(lvl), 64'h45);
        // R7: wake independent of enable
        bus(1, 0, 0, 32'h0, q);
        bus(1, 0, 2, 32'h8, q);
        setirq(64'd1 << 3);
        chk(wake == 1'b1, "R7 wake on enabled source", 64'(wake), 1);
        chk(lvl == '0, "R7 level off while disabled", 64'(lvl), 0);
        setirq(64'd1 << 4);
        chk(wake == 1'b0, "R7 no wake for other source", 64'(wake), 0);
        // R8: same-cycle read and write
        bus(1, 1, 0, 32'hA5A5_A5A5, q);
        chk(q == 32'h0, "R8 read returns pre-write value", 64'(q), 0);
        bus(0, 1, 0, 0, q);
        chk(q == 32'hA5A5_A5A5, "R9 enable word readback", 64'(q), 64'hA5A5A5A5);
        // R10: status views
        setirq(64'h0000_0000_1234_5678);
        bus(1, 0, 4, 32'h0, q);
        bus(1, 0, 6, 32'hFFFF_FFFF, q);
        bus(0, 1, 4, 0, q);
        chk(q == 32'h1234_5678, "R10 raw status live", 64'(q), 64'h12345678);
        bus(0, 1, 6, 0, q);
        chk(q == (32'h1234_5678 & 32'hA5A5_A5A5), "R10 masked status",
            64'(q), 64'(32'h1234_5678 & 32'hA5A5_A5A5));
        bus(0, 1, 0, 0, q);
        chk(q == 32'hA5A5_A5A5, "R10 status write left enable intact", 64'(q), 64'hA5A5A5A5);
        // R11: unmapped
        bus(1, 0, 20, 32'hFFFF_FFFF, q);
        bus(0, 1, 20, 0, q);
        chk(q == 32'h0, "R11 unmapped reads zero", 64'(q), 0);
        bus(0, 1, 8, 0, q);
        chk(q == 32'h0, "R11 unmapped write left word 8 intact", 64'(q), 0);
        // Random phase, checked by the model every cycle.
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            irq   = {rnd(), rnd()} & {rnd(), rnd()};
            wr_en = (rnd() % 4) == 0;
            rd_en = (rnd() % 2) == 0;
            addr  = AW'(rnd());
            wdata = rnd();
        end
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule